// File: doc/BRIEF.md
# Multi-Mode Encoder Position Counter

This block tracks shaft position from two encoder lines, A and B. It keeps a position register bounded by a programmable ceiling. Software picks one of four input modes:

- x4 quadrature, where every edge of either line counts and the phase order gives the direction;
- pulse with a direction level;
- count up only;
- count down only.

The count wraps at the ceiling and at zero. Each wrap, and each reversal of direction, sets a sticky event flag.

The event flags drive a single interrupt line through an enable mask. A global flag gates that line, and software clears the global flag and the event flags by writing ones. Both encoder lines pass through a two-flop synchroniser before any edge is detected. Software reaches the block through a small register port. Reads are combinational and writes take effect on the next clock edge.

Register addresses are 0 position, 1 ceiling, 2 decoder setup, 3 run control, 4 status (read-only), 5 event enable, 6 event flags (read-only) and 7 flag clear (write-only, reads 0).

Top module: `enc_pos_counter`

## Requirements
- R1: After reset the position is 0, the ceiling is all ones, the status reads 0x20 (forward), the flags read 0 and irq is low.
- R2: With decoder setup bits 15:14 = 00 (x4 quadrature), each legal Gray step counts once. The sequence {A,B} 00,10,11,01 counts up and the reverse sequence counts down.
- R3: In quadrature mode, a step in which A and B change together is ignored and leaves the position unchanged.
- R4: With bits 15:14 = 01 (pulse/direction), only rising edges of A count. B high counts up and B low counts down.
- R5: With bits 15:14 = 10 (up) or 11 (down), only rising edges of A count, in the fixed direction, and B has no effect.
- R6: In up and down modes, decoder setup bit 11 set makes both edges of A count.
- R7: With run control bit 3 clear, the position holds whatever the inputs do.
- R8: A position write above the ceiling is dropped and a write at or below it is taken. A count event in the same cycle as a position write is dropped.
- R9: Counting up from a position at or above the ceiling gives 0 and sets flag bit 6 (overflow).
- R10: Counting down from 0 gives the ceiling and sets flag bit 5 (underflow).
- R11: Status bit 5 shows the direction of the last count (1 = forward). A count opposite to that direction sets flag bit 3.
- R12: Flag bit 0 (global) is set only by an event whose enable bit (same position, register 5) is set. irq is high while bit 0 and at least one enabled event flag are set. Writing ones to register 7 clears the matching flag bits and leaves the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
An encoder line change reaches the position, status, flags and irq on the third rising edge after it: two synchroniser edges, then the edge that registers the count. A register write shows on the next rising edge.

The bench drives every input just after a falling edge. After an encoder change it waits four falling edges before it reads, and after a write it waits one full cycle. Every sample therefore falls half a cycle away from any edge, after the result is due.

// File: rtl/enc_pkg.sv
package enc_pkg;
    typedef enum logic [1:0] {
        MODE_QUAD   = 2'b00,
        MODE_DIRCNT = 2'b01,
        MODE_UP     = 2'b10,
        MODE_DOWN   = 2'b11
    } cnt_mode_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_POS  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MAX  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DEC  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STS  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLG  = 3'd6;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd7;

    localparam int FLAG_W   = 7;
    localparam int BIT_OVF  = 6;
    localparam int BIT_UNF  = 5;
    localparam int BIT_DCH  = 3;
    localparam int BIT_GLB  = 0;
    localparam logic [FLAG_W-1:0] EV_MASK = 7'b110_1000;

    localparam int DEC_MODE_LSB = 14;
    localparam int DEC_BOTH     = 11;
    localparam int CTL_EN       = 3;
    localparam int STS_DIR      = 5;

    // Position of a {A,B} pair along the forward Gray sequence.
    function automatic logic [1:0] gray_step(input logic a, input logic b);
        case ({a, b})
            2'b00:   gray_step = 2'd0;
            2'b10:   gray_step = 2'd1;
            2'b11:   gray_step = 2'd2;
            default: gray_step = 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] stg_d;
        if (i == 0) begin : g_first
            assign stg_d = d;
        end else begin : g_next
            assign stg_d = stg_q[i-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/enc_edge_decode.sv
module enc_edge_decode
    import enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a,
    input  logic      b,
    input  cnt_mode_e mode,
    input  logic      both_edge,
    output logic      evt,
    output logic      up
);
    typedef struct packed {
        logic a;
        logic b;
    } prev_t;

    prev_t      prev_d, prev_q;
    logic [1:0] step_diff;
    logic       rise_a, fall_a;

    always_comb begin
        prev_d    = '{a: a, b: b};
        step_diff = gray_step(a, b) - gray_step(prev_q.a, prev_q.b);
        rise_a    = a & ~prev_q.a;
        fall_a    = ~a & prev_q.a;
        evt       = 1'b0;
        up        = 1'b1;
        case (mode)
            MODE_QUAD: begin
                // diff 2 means both lines moved: illegal, dropped
                evt = (step_diff == 2'd1) || (step_diff == 2'd3);
                up  = (step_diff == 2'd1);
            end
            MODE_DIRCNT: begin
                evt = rise_a;
                up  = b;
            end
            MODE_UP: begin
                evt = rise_a | (both_edge & fall_a);
                up  = 1'b1;
            end
            default: begin
                evt = rise_a | (both_edge & fall_a);
                up  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/enc_pos_step.sv
module enc_pos_step #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] pos,
    input  logic [DATA_W-1:0] ceil,
    input  logic              take,
    input  logic              up,
    output logic [DATA_W-1:0] pos_next,
    output logic              ovf,
    output logic              unf
);
    always_comb begin
        pos_next = pos;
        ovf      = 1'b0;
        unf      = 1'b0;
        if (take) begin
            if (up) begin
                if (pos >= ceil) begin
                    pos_next = '0;
                    ovf      = 1'b1;
                end else begin
                    pos_next = pos + 1'b1;
                end
            end else begin
                if (pos == '0) begin
                    pos_next = ceil;
                    unf      = 1'b1;
                end else begin
                    pos_next = pos - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
    import enc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] pos;
        logic [DATA_W-1:0] ceil;
        cnt_mode_e         mode;
        logic              both;
        logic              en;
        logic              dir;
        logic [FLAG_W-1:0] ien;
        logic [FLAG_W-1:0] flg;
    } state_t;

    state_t            st_d, st_q;
    logic [1:0]        ab_sync;
    logic              cnt_evt, cnt_up, take;
    logic              pos_wr;
    logic [DATA_W-1:0] step_pos;
    logic              step_ovf, step_unf;
    logic [FLAG_W-1:0] ev_bits;

    // plain views for the bound checker
    logic [DATA_W-1:0] pos_q, max_q;
    logic              en_q;
    logic [FLAG_W-1:0] flags_q, ie_q;

    enc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({enc_a, enc_b}),
        .q    (ab_sync)
    );

    enc_edge_decode dec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .a        (ab_sync[1]),
        .b        (ab_sync[0]),
        .mode     (st_q.mode),
        .both_edge(st_q.both),
        .evt      (cnt_evt),
        .up       (cnt_up)
    );

    assign pos_wr = reg_we && (reg_addr == A_POS);
    assign take   = cnt_evt && st_q.en && !pos_wr;

    enc_pos_step #(.DATA_W(DATA_W)) step_i (
        .pos     (st_q.pos),
        .ceil    (st_q.ceil),
        .take    (take),
        .up      (cnt_up),
        .pos_next(step_pos),
        .ovf     (step_ovf),
        .unf     (step_unf)
    );

    always_comb begin
        st_d    = st_q;
        ev_bits = '0;

        if (pos_wr) begin
            if (reg_wdata <= st_q.ceil) st_d.pos = reg_wdata;
        end else begin
            st_d.pos = step_pos;
        end

        if (take) begin
            st_d.dir         = cnt_up;
            ev_bits[BIT_DCH] = (cnt_up != st_q.dir);
        end
        ev_bits[BIT_OVF] = step_ovf;
        ev_bits[BIT_UNF] = step_unf;

        if (reg_we) begin
            case (reg_addr)
                A_MAX: st_d.ceil = reg_wdata;
                A_DEC: begin
                    st_d.mode = cnt_mode_e'(reg_wdata[DEC_MODE_LSB +: 2]);
                    st_d.both = reg_wdata[DEC_BOTH];
                end
                A_CTL: st_d.en  = reg_wdata[CTL_EN];
                A_IEN: st_d.ien = reg_wdata[FLAG_W-1:0] & EV_MASK;
                A_CLR: st_d.flg = st_q.flg & ~reg_wdata[FLAG_W-1:0];
                default: ;
            endcase
        end

        // a new event wins over a clear in the same cycle
        st_d.flg = st_d.flg | ev_bits;
        if (|(ev_bits & st_q.ien)) st_d.flg[BIT_GLB] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ceil <= '1;
            st_q.mode <= MODE_QUAD;
            st_q.dir  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_POS: reg_rdata = st_q.pos;
            A_MAX: reg_rdata = st_q.ceil;
            A_DEC: begin
                reg_rdata[DEC_MODE_LSB +: 2] = st_q.mode;
                reg_rdata[DEC_BOTH]          = st_q.both;
            end
            A_CTL: reg_rdata[CTL_EN]   = st_q.en;
            A_STS: reg_rdata[STS_DIR]  = st_q.dir;
            A_IEN: reg_rdata[FLAG_W-1:0] = st_q.ien;
            A_FLG: reg_rdata[FLAG_W-1:0] = st_q.flg;
            default: ;
        endcase
    end

    assign irq     = st_q.flg[BIT_GLB] && |(st_q.flg & st_q.ien & EV_MASK);
    assign pos_q   = st_q.pos;
    assign max_q   = st_q.ceil;
    assign en_q    = st_q.en;
    assign flags_q = st_q.flg;
    assign ie_q    = st_q.ien;
endmodule

// File: rtl/enc_pos_counter_chk.sv
module enc_pos_counter_chk
    import enc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic [DATA_W-1:0] pos_q,
    input logic [DATA_W-1:0] max_q,
    input logic              en_q,
    input logic [FLAG_W-1:0] flags_q,
    input logic [FLAG_W-1:0] ie_q
);
    a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !(reg_we && reg_addr == A_POS)) |=> $stable(pos_q));

    a_r8_reject_above_max: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_POS && reg_wdata > max_q) |=> $stable(pos_q));

    a_r8_accept_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_POS && reg_wdata <= max_q) |=> (pos_q == $past(reg_wdata)));

    a_r9_overflow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[BIT_OVF]) |-> ($past(pos_q) >= $past(max_q) && pos_q == '0));

    a_r10_underflow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[BIT_UNF]) |-> ($past(pos_q) == '0 && pos_q == $past(max_q)));

    a_r12_irq_needs_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags_q[BIT_GLB] && |(flags_q & ie_q)));
endmodule

bind enc_pos_counter enc_pos_counter_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq      (irq),
    .pos_q    (pos_q),
    .max_q    (max_q),
    .en_q     (en_q),
    .flags_q  (flags_q),
    .ie_q     (ie_q)
);

// File: tb/enc_pos_counter_tb_top.sv
module enc_pos_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    enc_pos_counter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] addr, input logic [31:0] exp);
        reg_addr = addr;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic enc(input logic a, input logic b);
        @(negedge clk);
        enc_a = a; enc_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 pos", 3'd0, 32'h0);
        rd_chk("R1 max", 3'd1, 32'hFFFF_FFFF);
        rd_chk("R1 status", 3'd4, 32'h20);
        rd_chk("R1 flags", 3'd6, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_quad;
        wr(3'd3, 32'h8);
        enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
        rd_chk("R2 quad up", 3'd0, 32'd4);
        rd_chk("R11 forward", 3'd4, 32'h20);
        rd_chk("R11 no reversal", 3'd6, 32'h0);
        enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
        rd_chk("R2 quad down", 3'd0, 32'd0);
        rd_chk("R11 backward", 3'd4, 32'h0);
        rd_chk("R11 reversal flag", 3'd6, 32'h08);
        wr(3'd7, 32'h7F);
        enc(1, 1);
        rd_chk("R3 illegal step", 3'd0, 32'd0);
        enc(0, 0);
        rd_chk("R3 illegal back", 3'd0, 32'd0);
    endtask

    task automatic t_hold;
        wr(3'd3, 32'h0);
        enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
        rd_chk("R7 held", 3'd0, 32'd0);
        wr(3'd3, 32'h8);
    endtask

    task automatic t_dircnt;
        wr(3'd2, 32'h4000);
        enc(1, 1); enc(0, 1); enc(1, 1);
        rd_chk("R4 up by B high", 3'd0, 32'd2);
        wr(3'd7, 32'h7F);
        enc(0, 0); enc(1, 0);
        rd_chk("R4 down by B low", 3'd0, 32'd1);
        rd_chk("R11 status back", 3'd4, 32'h0);
    endtask

    task automatic t_updown;
        wr(3'd2, 32'h8000);
        enc(0, 0); enc(1, 0); enc(0, 1); enc(1, 1); enc(0, 0);
        rd_chk("R5 up rising only, B ignored", 3'd0, 32'd3);
        wr(3'd2, 32'h8800);
        enc(1, 0); enc(0, 0);
        rd_chk("R6 up both edges", 3'd0, 32'd5);
        wr(3'd2, 32'hC000);
        enc(1, 0); enc(0, 0);
        rd_chk("R5 down rising only", 3'd0, 32'd4);
        wr(3'd2, 32'hC800);
        enc(1, 0); enc(0, 0);
        rd_chk("R6 down both edges", 3'd0, 32'd2);
    endtask

    task automatic t_limits;
        wr(3'd1, 32'd10);
        wr(3'd0, 32'd11);
        rd_chk("R8 write above max dropped", 3'd0, 32'd2);
        wr(3'd0, 32'd10);
        rd_chk("R8 write at max taken", 3'd0, 32'd10);
        wr(3'd7, 32'h7F);
        wr(3'd5, 32'h40);
        wr(3'd2, 32'h8000);
        enc(1, 0);
        rd_chk("R9 wrap to zero", 3'd0, 32'd0);
        rd_chk("R9 overflow+reversal+global", 3'd6, 32'h49);
        chk("R12 irq on enabled event", {31'b0, irq}, 32'h1);
        wr(3'd7, 32'h49);
        rd_chk("R12 flags cleared", 3'd6, 32'h0);
        chk("R12 irq dropped", {31'b0, irq}, 32'h0);
        enc(0, 0);
        wr(3'd2, 32'hC000);
        enc(1, 0);
        rd_chk("R10 wrap to max", 3'd0, 32'd10);
        rd_chk("R10 underflow, no global", 3'd6, 32'h28);
        chk("R12 masked event no irq", {31'b0, irq}, 32'h0);
        wr(3'd7, 32'h20);
        rd_chk("R12 partial clear", 3'd6, 32'h08);
        enc(0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quad();
        t_hold();
        t_dircnt();
        t_updown();
        t_limits();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule